// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a 24-bit virtual address into a 24-bit physical memory address. It looks the address up in a 512-entry translation table that lives inside the block. The virtual address is read from the top bit down as four fields:

| Bits | Field |
|------|-------|
| 23 | direct-address bit |
| 22:18 | five-bit segment |
| 17:12 | six-bit page |
| 11:0 | twelve-bit displacement |

The table is indexed by the low three segment bits followed by the page bits, which gives eight segments of 64 pages each. Each entry holds a 13-bit frame number, a page-size bit and a valid bit. The page-size bit picks a 2 KB or a 4 KB page for that entry alone.

The surrounding core raises a one-cycle request strobe together with the address and the mode flags. One clock later the block answers with exactly one of three results:

- a valid strobe carrying the physical address;
- a paging-error flag, for a missing entry or a displacement that overflows a 2 KB page;
- a program-addressing error flag, for nonzero reserved segment bits.

Addresses bypass the table when translation is off or the access is for I/O. Privileged code can also ask for a direct, untranslated address through the top bit. Software loads the table through a synchronous write port.

Top module: `seg_page_xlate`

## Requirements
- R1: When `xlate_en` is 0 or `io_acc` is 1, a request yields `paddr_vld` with `paddr` equal to `vaddr`. No error is raised, whatever the other bits hold.
- R2: In translate mode the table index is `{vaddr[20:18], vaddr[17:12]}`, so segment 7 page 63 selects entry 511.
- R3: In translate mode with `base_seg`=1, a nonzero value in `vaddr[22:21]` raises `addr_err` and no valid strobe. This check comes before every other translate-mode rule.
- R4: In translate mode with `base_seg`=1, `vaddr[23]`=1 and `priv`=1, the result is valid with `paddr` = `{1'b0, vaddr[22:0]}`. With `priv`=0 the address is translated through the table instead.
- R5: When `base_seg` is 0, the direct bit and all five segment bits are treated as zero. The reserved-bit check cannot fire and the lookup uses segment 0.
- R6: A valid entry whose size bit is 1 (2 KB page) with `vaddr[11]`=0 gives `paddr` = `{frame[12:0], vaddr[10:0]}`.
- R7: A valid entry whose size bit is 1 with `vaddr[11]`=1 raises `page_err` and no valid strobe.
- R8: A valid entry whose size bit is 0 (4 KB page) gives `paddr` = `{frame[12:1], vaddr[11:0]}`.
- R9: A lookup of an entry whose valid bit is 0 raises `page_err`. Reset clears every entry's valid bit.
- R10: Every request produces exactly one result in the following cycle: `paddr_vld`, `page_err` or `addr_err`, never two at once. A cycle without a request produces none. `paddr` is zero whenever `paddr_vld` is low.
- R11: A table write at `wr_idx` is seen by requests in later cycles. A request in the same cycle as the write sees the old contents.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Translation request strobe |
| vaddr | input | 24 | Virtual address |
| xlate_en | input | 1 | Translate mode enable |
| priv | input | 1 | Privileged mode (1 = privileged) |
| base_seg | input | 1 | A base register supplied the segment and direct bit |
| io_acc | input | 1 | Access belongs to I/O and is never translated |
| wr_en | input | 1 | Table write enable |
| wr_idx | input | 9 | Table entry written |
| wr_frame | input | 13 | Frame number to store |
| wr_half | input | 1 | Size bit to store (1 = 2 KB page) |
| wr_valid | input | 1 | Valid bit to store |
| paddr | output | 24 | Physical address |
| paddr_vld | output | 1 | Physical address valid strobe |
| page_err | output | 1 | Paging error strobe |
| addr_err | output | 1 | Program-addressing error strobe |

## Verification
The hardest case to reach from the ports is a lookup that collides with a table write. A same-cycle request must see the entry as it was before the write and the next request must see it after. The bench first leaves one entry unwritten and confirms it reports a paging error. It then writes that entry while requesting it in the same cycle, and repeats the request one cycle later. The interplay of the base-register flag with the direct and reserved bits is reached by sending the same virtual address under different flag settings. A second hard case is a 2 KB page whose displacement spills into the upper half. The bench reaches it by loading one entry with the small-page bit and requesting an address with displacement bit 11 set.

// File: rtl/seg_page_xlate.sv
module seg_page_xlate #(
  parameter int SEG_W     = 5,
  parameter int IDX_SEG_W = 3,
  parameter int PAGE_W    = 6,
  parameter int DISP_W    = 12,
  parameter int FRAME_W   = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req,
  input  logic [SEG_W+PAGE_W+DISP_W:0]  vaddr,
  input  logic                          xlate_en,
  input  logic                          priv,
  input  logic                          base_seg,
  input  logic                          io_acc,
  input  logic                          wr_en,
  input  logic [IDX_SEG_W+PAGE_W-1:0]   wr_idx,
  input  logic [FRAME_W-1:0]            wr_frame,
  input  logic                          wr_half,
  input  logic                          wr_valid,
  output logic [SEG_W+PAGE_W+DISP_W:0]  paddr,
  output logic                          paddr_vld,
  output logic                          page_err,
  output logic                          addr_err
);
  localparam int VA_W  = SEG_W + PAGE_W + DISP_W + 1;
  localparam int IDX_W = IDX_SEG_W + PAGE_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [FRAME_W:0]   tbl [DEPTH];
  logic [DEPTH-1:0]   ent_ok;

  wire [DISP_W-1:0] disp = vaddr[DISP_W-1:0];
  wire [PAGE_W-1:0] page = vaddr[DISP_W +: PAGE_W];
  wire [SEG_W-1:0]  seg  = base_seg ? vaddr[DISP_W+PAGE_W +: SEG_W] : '0;
  wire              dbit = base_seg & vaddr[VA_W-1];
  wire [IDX_W-1:0]  idx  = {seg[IDX_SEG_W-1:0], page};

  wire [FRAME_W-1:0] frame = tbl[idx][FRAME_W-1:0];
  wire               half  = tbl[idx][FRAME_W];
  wire               hit   = ent_ok[idx];

  wire bypass  = !xlate_en || io_acc;
  wire rsv_bad = |seg[SEG_W-1:IDX_SEG_W];
  wire direct  = dbit & priv;
  wire pg_bad  = !hit || (half && disp[DISP_W-1]);

  wire [VA_W-1:0] xl_addr = half ? {frame, disp[DISP_W-2:0]}
                                 : {frame[FRAME_W-1:1], disp};

  always_ff @(posedge clk)
    if (wr_en) tbl[wr_idx] <= {wr_half, wr_frame};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ent_ok <= '0;
    else if (wr_en) ent_ok[wr_idx] <= wr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr     <= '0;
      paddr_vld <= 1'b0;
      page_err  <= 1'b0;
      addr_err  <= 1'b0;
    end else begin
      paddr     <= '0;
      paddr_vld <= 1'b0;
      page_err  <= 1'b0;
      addr_err  <= 1'b0;
      if (req) begin
        if (bypass) begin
          paddr     <= vaddr;
          paddr_vld <= 1'b1;
        end else if (rsv_bad) begin
          addr_err  <= 1'b1;
        end else if (direct) begin
          paddr     <= {1'b0, vaddr[VA_W-2:0]};
          paddr_vld <= 1'b1;
        end else if (pg_bad) begin
          page_err  <= 1'b1;
        end else begin
          paddr     <= xl_addr;
          paddr_vld <= 1'b1;
        end
      end
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({paddr_vld, page_err, addr_err}));

  a_r10_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (paddr_vld || page_err || addr_err));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !(paddr_vld || page_err || addr_err));

  a_r10_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !paddr_vld |-> (paddr == '0));

  a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (!xlate_en || io_acc)) |=> (paddr_vld && paddr == $past(vaddr)));

  a_r3_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (req && xlate_en && !io_acc && base_seg && |vaddr[VA_W-2 -: SEG_W-IDX_SEG_W])
      |=> addr_err);

  a_r5_no_addr_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !base_seg) |=> !addr_err);
endmodule

// File: tb/seg_page_xlate_bench.sv
`timescale 1ns/1ps
module seg_page_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] vaddr = '0;
  logic        xlate_en = 1'b0, priv = 1'b0, base_seg = 1'b0, io_acc = 1'b0;
  logic        wr_en = 1'b0, wr_half = 1'b0, wr_valid = 1'b0;
  logic [8:0]  wr_idx = '0;
  logic [12:0] wr_frame = '0;
  logic [23:0] paddr;
  logic        paddr_vld, page_err, addr_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  seg_page_xlate u_seg_page_xlate (
    .clk(clk), .rst_n(rst_n), .req(req), .vaddr(vaddr), .xlate_en(xlate_en),
    .priv(priv), .base_seg(base_seg), .io_acc(io_acc), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_frame(wr_frame), .wr_half(wr_half), .wr_valid(wr_valid),
    .paddr(paddr), .paddr_vld(paddr_vld), .page_err(page_err), .addr_err(addr_err)
  );

  // {xlate_en, io_acc, priv, base_seg, vaddr, vld, page_err, addr_err, paddr}
  localparam int NV = 13;
  localparam logic [54:0] VEC [NV] = '{
    {4'b1001, 24'h0007FF, 3'b100, 24'h55E7FF},
    {4'b1001, 24'h161123, 3'b100, 24'h91A123},
    {4'b1001, 24'h161923, 3'b010, 24'h000000},
    {4'b1001, 24'h1FFABC, 3'b100, 24'hFFFABC},
    {4'b1001, 24'h002005, 3'b010, 24'h000000},
    {4'b1001, 24'h200000, 3'b001, 24'h000000},
    {4'b1000, 24'h200000, 3'b100, 24'h55E000},
    {4'b1011, 24'h961123, 3'b100, 24'h161123},
    {4'b1001, 24'h961123, 3'b100, 24'h91A123},
    {4'b1010, 24'h800010, 3'b100, 24'h55E010},
    {4'b0001, 24'hABCDEF, 3'b100, 24'hABCDEF},
    {4'b1101, 24'h200000, 3'b100, 24'h200000},
    {4'b1000, 24'h1FFABC, 3'b010, 24'h000000}
  };
  string tags [NV];

  task automatic check(input string rq, input logic [26:0] act, input logic [26:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got vld/pe/ae/paddr=%b/%b/%b/%h expected %b/%b/%b/%h",
               rq, act[26], act[25], act[24], act[23:0],
               exp[26], exp[25], exp[24], exp[23:0]);
    end
  endtask

  function automatic logic [26:0] outs();
    return {paddr_vld, page_err, addr_err, paddr};
  endfunction

  task automatic wr(input logic [8:0] i, input logic [12:0] f, input logic h, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_frame = f; wr_half = h; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ask(input logic [3:0] fl, input logic [23:0] a);
    @(negedge clk);
    {xlate_en, io_acc, priv, base_seg} = fl;
    vaddr = a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tags = '{"R8", "R6", "R7", "R2", "R9", "R3", "R5", "R4", "R4", "R5", "R1", "R1", "R5"};
    repeat (3) @(negedge clk);
    check("R12", outs(), 27'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", outs(), 27'd0);

    wr(9'h000, 13'h0ABC, 1'b0, 1'b1);
    wr(9'h161, 13'h1234, 1'b1, 1'b1);
    wr(9'h1FF, 13'h1FFF, 1'b0, 1'b1);
    check("R10", outs(), 27'd0);

    for (int k = 0; k < NV; k++) begin
      ask(VEC[k][54:51], VEC[k][50:27]);
      check(tags[k], outs(), VEC[k][26:0]);
    end

    @(negedge clk);
    check("R10", outs(), 27'd0);

    // R11: same-cycle write and lookup of entry 2 sees the old (invalid) entry
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 9'h002; wr_frame = 13'h0010; wr_half = 1'b1; wr_valid = 1'b1;
    {xlate_en, io_acc, priv, base_seg} = 4'b1001;
    vaddr = 24'h002005; req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; req = 1'b0;
    check("R11", outs(), {3'b010, 24'h0});
    ask(4'b1001, 24'h002005);
    check("R11", outs(), {3'b100, 24'h008005});

    // R9: clearing the valid bit makes the entry miss again
    wr(9'h002, 13'h0010, 1'b1, 1'b0);
    ask(4'b1001, 24'h002005);
    check("R9", outs(), {3'b010, 24'h0});

    // R9: reset clears all valid bits
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    ask(4'b1001, 24'h161123);
    check("R9", outs(), {3'b010, 24'h0});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule